// File: doc/BRIEF.md
# Dual-clock first-word-fall-through FIFO

This block moves 36-bit words from one clock domain to another through a 1024-word store. The producer writes on its own clock. The consumer reads on an unrelated clock. On the read side the oldest word is presented before it is requested: when the output-ready flag is high, the word is already in the read data register. A read request consumes that word and brings forward the next one.

Both sides report how far the store is from its limits. The write side drives a full flag and an almost-full flag. The read side drives an almost-empty flag. A two-bit threshold selection is captured as reset is released and sets the margin for both the almost-full and almost-empty flags. Pointers cross between the domains as Gray code through two-stage synchronizers, so each flag reflects the other side's progress with a few cycles of delay.

Top module: `xfifo_fwft_dc`

## Requirements
- R1: Words are 36 bits wide and the store holds 1024 words. Words leave on `rd_data` in exactly the order in which they were accepted on the write side, and none is duplicated or dropped.
- R2: While `out_ready` is high, `rd_data` holds the oldest unread word, with no read request needed to fetch it. Without a read request, that word and `out_ready` stay unchanged.
- R3: While `out_ready` is low, a read request has no effect: no word is consumed, and the next word written is the next word presented.
- R4: When a word is written into an empty FIFO, `out_ready` rises on the third rising `rd_clk` edge after the `wr_clk` edge that stored the word.
- R5: A read request while `out_ready` is high replaces `rd_data` with the next word at the following `rd_clk` edge. If no further word has reached the read side, `out_ready` drops instead.
- R6: `full` is high when the write side counts 1024 words in the store that have not yet moved to the read output register, so the FIFO holds up to 1025 words in total. A write while `full` is high is ignored.
- R7: While `rst_n` is low, `out_ready`, `full` and `almost_full` are low and `almost_empty` is high.
- R8: `thr_sel` is captured as reset is released and chooses the threshold margin: 0 gives 4 words, 1 gives 8, 2 gives 16 and 3 gives 64. Changes to `thr_sel` after release have no effect until the next reset.
- R9: `almost_full` is high when the write-side count (words accepted minus the synchronized read pointer) is at least 1024 minus the margin.
- R10: `almost_empty` is high when the read-side count (synchronized words written minus the read pointer, plus one if `out_ready` is high) is at most the margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset for both domains; its release captures `thr_sel` |
| thr_sel | input | 2 | Threshold margin selection for the almost flags |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | 36 | Word to store |
| full | output | 1 | Store full as seen from the write side |
| almost_full | output | 1 | Write-side count within the margin of full |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | 36 | Registered oldest word |
| out_ready | output | 1 | `rd_data` holds a valid word |
| almost_empty | output | 1 | Read-side count at or below the margin |

## Verification
Two read-side functions can land on the same `rd_clk` edge. A read request can retire the word in the output register while a newly synchronized write pointer makes the next word available, so the pop and the reload happen together. A further word may also arrive from the write domain on that same edge. These coincidences are provoked by running both sides at the same time with irregular request patterns on clocks of unrelated period, at rates that let the FIFO both drain to empty and fill to full. They are judged against a behavioural model that advances its own counts and synchronizer delays on each edge, and compares `out_ready`, `rd_data` and every flag on every clock.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    typedef enum logic [1:0] {
        OFS_SEL_0 = 2'd0,
        OFS_SEL_1 = 2'd1,
        OFS_SEL_2 = 2'd2,
        OFS_SEL_3 = 2'd3
    } ofs_sel_e;

    function automatic int unsigned pick_offset(
        input ofs_sel_e    s,
        input int unsigned o0,
        input int unsigned o1,
        input int unsigned o2,
        input int unsigned o3
    );
        int unsigned r;
        case (s)
            OFS_SEL_0: r = o0;
            OFS_SEL_1: r = o1;
            OFS_SEL_2: r = o2;
            default:   r = o3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xfifo_sync2.sv
module xfifo_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [0:DEPTH-1];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
    import xfifo_pkg::*;
#(
    parameter int          AW   = 10,
    parameter int unsigned OFS0 = 4,
    parameter int unsigned OFS1 = 8,
    parameter int unsigned OFS2 = 16,
    parameter int unsigned OFS3 = 64
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic [1:0]    thr_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rd_gray_in,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wr_gray,
    output logic          full,
    output logic          almost_full
);
    localparam int          PW    = AW + 1;
    localparam int          LW    = PW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        ofs_sel_e      sel;
    } wst_t;

    wst_t          st_d, st_q;
    logic          live;
    logic [PW-1:0] rg_sync;
    logic [PW-1:0] rg_bin;
    logic [PW-1:0] level;
    logic [LW-1:0] fill_w;
    logic [LW-1:0] off_w;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    xfifo_sync2 #(.W(1)) u_live_sync (
        .clk  (wr_clk),
        .rst_n(rst_n),
        .d    (1'b1),
        .q    (live)
    );

    xfifo_sync2 #(.W(PW)) u_rptr_sync (
        .clk  (wr_clk),
        .rst_n(rst_n),
        .d    (rd_gray_in),
        .q    (rg_sync)
    );

    always_comb begin
        rg_bin      = gray_to_bin(rg_sync);
        level       = st_q.ptr - rg_bin;
        fill_w      = {1'b0, level};
        off_w       = LW'(pick_offset(st_q.sel, OFS0, OFS1, OFS2, OFS3));
        full        = (fill_w == LW'(DEPTH));
        almost_full = (fill_w >= (LW'(DEPTH) - off_w));
        mem_we      = 1'b0;
        st_d        = st_q;
        if (!live) begin
            st_d.sel = ofs_sel_e'(thr_sel);
        end else if (wr_en && !full) begin
            mem_we    = 1'b1;
            st_d.ptr  = st_q.ptr + PW'(1);
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.gray <= '0;
            st_q.sel  <= OFS_SEL_0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_waddr = st_q.ptr[AW-1:0];
    assign wr_gray   = st_q.gray;
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
    import xfifo_pkg::*;
#(
    parameter int          AW   = 10,
    parameter int          DW   = 36,
    parameter int unsigned OFS0 = 4,
    parameter int unsigned OFS1 = 8,
    parameter int unsigned OFS2 = 16,
    parameter int unsigned OFS3 = 64
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic [1:0]    thr_sel,
    input  logic          rd_en,
    input  logic [AW:0]   wr_gray_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rd_gray,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          almost_empty
);
    localparam int PW = AW + 1;
    localparam int LW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [DW-1:0] data;
        logic          valid;
        ofs_sel_e      sel;
    } rst_t;

    rst_t          st_d, st_q;
    logic          live;
    logic [PW-1:0] wg_sync;
    logic [PW-1:0] wg_bin;
    logic [PW-1:0] span;
    logic [LW-1:0] held;
    logic [LW-1:0] off_w;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    xfifo_sync2 #(.W(1)) u_live_sync (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .d    (1'b1),
        .q    (live)
    );

    xfifo_sync2 #(.W(PW)) u_wptr_sync (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .d    (wr_gray_in),
        .q    (wg_sync)
    );

    always_comb begin
        wg_bin       = gray_to_bin(wg_sync);
        span         = wg_bin - st_q.ptr;
        held         = {1'b0, span} + LW'(st_q.valid);
        off_w        = LW'(pick_offset(st_q.sel, OFS0, OFS1, OFS2, OFS3));
        almost_empty = (held <= off_w);
        st_d         = st_q;
        if (!live) begin
            st_d.sel = ofs_sel_e'(thr_sel);
        end else if ((!st_q.valid || rd_en) && (span != '0)) begin
            st_d.data  = mem_rdata;
            st_d.valid = 1'b1;
            st_d.ptr   = st_q.ptr + PW'(1);
            st_d.gray  = st_d.ptr ^ (st_d.ptr >> 1);
        end else if (rd_en) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr   <= '0;
            st_q.gray  <= '0;
            st_q.data  <= '0;
            st_q.valid <= 1'b0;
            st_q.sel   <= OFS_SEL_0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr = st_q.ptr[AW-1:0];
    assign rd_gray   = st_q.gray;
    assign rd_data   = st_q.data;
    assign out_ready = st_q.valid;
endmodule

// File: rtl/xfifo_fwft_dc.sv
module xfifo_fwft_dc #(
    parameter int          DW   = 36,
    parameter int          AW   = 10,
    parameter int unsigned OFS0 = 4,
    parameter int unsigned OFS1 = 8,
    parameter int unsigned OFS2 = 16,
    parameter int unsigned OFS3 = 64
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic [1:0]    thr_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          almost_full,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          almost_empty
);
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [AW:0]   wr_gray;
    logic [AW:0]   rd_gray;

    xfifo_wr_ctl #(
        .AW(AW), .OFS0(OFS0), .OFS1(OFS1), .OFS2(OFS2), .OFS3(OFS3)
    ) u_wr (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .thr_sel    (thr_sel),
        .wr_en      (wr_en),
        .rd_gray_in (rd_gray),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wr_gray    (wr_gray),
        .full       (full),
        .almost_full(almost_full)
    );

    xfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk (wr_clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(wr_data),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    xfifo_rd_ctl #(
        .AW(AW), .DW(DW), .OFS0(OFS0), .OFS1(OFS1), .OFS2(OFS2), .OFS3(OFS3)
    ) u_rd (
        .rd_clk      (rd_clk),
        .rst_n       (rst_n),
        .thr_sel     (thr_sel),
        .rd_en       (rd_en),
        .wr_gray_in  (wr_gray),
        .mem_rdata   (mem_rdata),
        .mem_raddr   (mem_raddr),
        .rd_gray     (rd_gray),
        .rd_data     (rd_data),
        .out_ready   (out_ready),
        .almost_empty(almost_empty)
    );
endmodule

// File: rtl/xfifo_checker.sv
module xfifo_checker #(
    parameter int PW = 11,
    parameter int DW = 36
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          full,
    input logic          almost_full,
    input logic          rd_en,
    input logic          out_ready,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] rd_gray
);
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wr_gray)); // R6

    AST_FULL_IMPLIES_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full); // R9

    AST_EMPTY_KEEPS_RPTR: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !out_ready |=> ($stable(rd_gray) || out_ready)); // R3

    AST_READY_HOLDS_WORD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (out_ready && !rd_en) |=> (out_ready && $stable(rd_data))); // R2

    AST_WPTR_SINGLE_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R1

    AST_RPTR_SINGLE_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1); // R5
endmodule

bind xfifo_fwft_dc xfifo_checker #(.PW(AW + 1), .DW(DW)) u_chk (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .full       (full),
    .almost_full(almost_full),
    .rd_en      (rd_en),
    .out_ready  (out_ready),
    .rd_data    (rd_data),
    .wr_gray    (wr_gray),
    .rd_gray    (rd_gray)
);

// File: tb/xfifo_fwft_dc_bench.sv
module xfifo_fwft_dc_bench;
    localparam int WR_PERIOD   = 10;
    localparam int RD_PERIOD   = 14;
    localparam int DEPTH       = 1024;
    localparam int WATCHDOG_NS = 3000000;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  thr_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        full;
    logic        almost_full;
    logic [35:0] rd_data;
    logic        out_ready;
    logic        almost_empty;

    xfifo_fwft_dc u_xfifo_fwft_dc (
        .wr_clk      (wr_clk),
        .rd_clk      (rd_clk),
        .rst_n       (rst_n),
        .thr_sel     (thr_sel),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .full        (full),
        .almost_full (almost_full),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .out_ready   (out_ready),
        .almost_empty(almost_empty)
    );

    initial forever #(WR_PERIOD / 2) wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #(RD_PERIOD / 2) rd_clk = ~rd_clk;
    end

    int  nvec = 0;
    int  nfail = 0;
    bit  cmp_en = 1'b0;
    int  rd_edges = 0;

    // behavioural reference state
    int          wcnt = 0, rcnt = 0;
    int          ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
    int          m_off = 4;
    bit          m_ov = 1'b0, m_full = 1'b0, m_af = 1'b0, m_ae = 1'b1;
    logic [35:0] m_od = '0;
    logic [35:0] mq[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge wr_clk) begin
        if (!rst_n) begin
            wcnt = 0; ws1 = 0; ws2 = 0; m_full = 1'b0; m_af = 1'b0;
            mq.delete();
        end else begin
            if (wr_en && (wcnt - ws2) < DEPTH) begin
                mq.push_back(wr_data);
                wcnt++;
            end
            ws2 = ws1;
            ws1 = rcnt;
            m_full = ((wcnt - ws2) == DEPTH);
            m_af   = ((wcnt - ws2) >= DEPTH - m_off);
        end
    end

    always @(posedge rd_clk) begin
        rd_edges++;
        if (!rst_n) begin
            rcnt = 0; rs1 = 0; rs2 = 0; m_ov = 1'b0; m_ae = 1'b1;
        end else begin
            if ((!m_ov || rd_en) && rs2 > rcnt) begin
                m_od = mq.pop_front();
                rcnt++;
                m_ov = 1'b1;
            end else if (rd_en) begin
                m_ov = 1'b0;
            end
            rs2 = rs1;
            rs1 = wcnt;
            m_ae = ((rs2 - rcnt + int'(m_ov)) <= m_off);
        end
    end

    always @(negedge wr_clk) begin
        if (cmp_en) begin
            check(full === m_full, "R6 full vs model", 64'(full), 64'(m_full));
            check(almost_full === m_af, "R9 almost_full vs model", 64'(almost_full), 64'(m_af));
        end
    end

    always @(negedge rd_clk) begin
        if (cmp_en) begin
            check(out_ready === m_ov, "R4 out_ready vs model", 64'(out_ready), 64'(m_ov));
            check(almost_empty === m_ae, "R10 almost_empty vs model", 64'(almost_empty), 64'(m_ae));
            if (m_ov) check(rd_data === m_od, "R1 rd_data vs model", 64'(rd_data), 64'(m_od));
        end
    end

    function automatic int offset_for(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 8;
            2'd2: return 16;
            default: return 64;
        endcase
    endfunction

    task automatic do_reset(input logic [1:0] sel);
        @(negedge rd_clk);
        cmp_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        thr_sel = sel;
        rst_n = 1'b0;
        repeat (6) @(negedge rd_clk);
        check(out_ready === 1'b0, "R7 out_ready in reset", 64'(out_ready), 64'(0));
        check(full === 1'b0, "R7 full in reset", 64'(full), 64'(0));
        check(almost_full === 1'b0, "R7 almost_full in reset", 64'(almost_full), 64'(0));
        check(almost_empty === 1'b1, "R7 almost_empty in reset", 64'(almost_empty), 64'(1));
        m_off = offset_for(sel);
        rst_n = 1'b1;
        repeat (5) @(negedge rd_clk);
        thr_sel = ~sel;   // R8: later change must not matter
        cmp_en = 1'b1;
    endtask

    task automatic push_word(input logic [35:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 50 && !out_ready; i++) @(negedge rd_clk);
    endtask

    task automatic drain(output int cnt, input bit seq);
        int idle = 0;
        cnt = 0;
        @(negedge rd_clk);
        rd_en = 1'b1;
        while (idle < 8) begin
            if (out_ready) begin
                if (seq) check(rd_data === 36'(cnt), "R1 drain order", 64'(rd_data), 64'(cnt));
                cnt++;
                idle = 0;
            end else begin
                idle++;
            end
            @(negedge rd_clk);
        end
        rd_en = 1'b0;
    endtask

    initial begin
        #(WATCHDOG_NS);
        nfail++;
        $display("FAIL R1 watchdog expired got %0d exp %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int e0, lat, cnt;
        do_reset(2'd0);

        // R4 latency and R2 fall-through
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = 36'h0A5A5A5A5;
        @(posedge wr_clk);
        e0 = rd_edges;
        @(negedge wr_clk);
        wr_en = 1'b0;
        while (!out_ready && (rd_edges - e0) < 20) @(negedge rd_clk);
        lat = rd_edges - e0;
        check(lat == 3, "R4 ready latency in rd edges", 64'(lat), 64'(3));
        check(rd_data === 36'h0A5A5A5A5, "R2 word present without request", 64'(rd_data), 64'h0A5A5A5A5);
        repeat (3) @(negedge rd_clk);
        check(out_ready && rd_data === 36'h0A5A5A5A5, "R2 word held without request", 64'(rd_data), 64'h0A5A5A5A5);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(out_ready === 1'b0, "R5 ready clears when none left", 64'(out_ready), 64'(0));

        // R5 pop brings next word
        push_word(36'h111);
        push_word(36'h222);
        repeat (10) @(negedge rd_clk);
        check(rd_data === 36'h111, "R2 oldest first", 64'(rd_data), 64'h111);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(out_ready && rd_data === 36'h222, "R5 pop advances", 64'(rd_data), 64'h222);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(out_ready === 1'b0, "R5 last pop clears ready", 64'(out_ready), 64'(0));

        // R3 reads while empty are ignored
        rd_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge rd_clk);
            check(out_ready === 1'b0, "R3 empty stays empty", 64'(out_ready), 64'(0));
        end
        rd_en = 1'b0;
        push_word(36'h333);
        wait_ready();
        check(out_ready && rd_data === 36'h333, "R3 no word lost to empty reads", 64'(rd_data), 64'h333);
        drain(cnt, 1'b0);

        // R8 capture at release, later change ignored
        do_reset(2'd3);
        for (int i = 0; i < 10; i++) push_word(36'(i));
        repeat (12) @(negedge rd_clk);
        check(almost_empty === 1'b1, "R8 margin 64 captured", 64'(almost_empty), 64'(1));
        do_reset(2'd0);
        for (int i = 0; i < 10; i++) push_word(36'(i));
        repeat (12) @(negedge rd_clk);
        check(almost_empty === 1'b0, "R8 margin 4 kept after sel change", 64'(almost_empty), 64'(0));

        // R6 R9 R10 fill and drain for every margin
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            for (int i = 0; i < 1100; i++) begin
                @(negedge wr_clk);
                wr_en = 1'b1; wr_data = 36'(i);
            end
            @(negedge wr_clk);
            wr_en = 1'b0;
            repeat (10) @(negedge wr_clk);
            check(full === 1'b1, "R6 full after overfill", 64'(full), 64'(1));
            check(almost_full === 1'b1, "R9 almost_full after overfill", 64'(almost_full), 64'(1));
            drain(cnt, 1'b1);
            check(cnt == DEPTH + 1, "R6 capacity and overflow ignored", 64'(cnt), 64'(DEPTH + 1));
            check(almost_empty === 1'b1, "R10 almost_empty after drain", 64'(almost_empty), 64'(1));
        end

        // concurrent irregular traffic
        do_reset(2'd1);
        fork
            begin
                for (int i = 0; i < 3000; i++) begin
                    @(negedge wr_clk);
                    wr_en = ($urandom_range(0, 3) != 0);
                    wr_data = {4'h5, 32'($urandom)};
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 2200; i++) begin
                    @(negedge rd_clk);
                    rd_en = (i < 1100) ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 2) != 0);
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
            end
        join
        drain(cnt, 1'b0);
        check(out_ready === 1'b0, "R5 empty after final drain", 64'(out_ready), 64'(0));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule